// File: doc/BRIEF.md
# Read-Triggered Sleep State Controller

This block watches a register bus for reads of three trigger bytes inside the power-management window. Each trigger byte asks the clock control logic for a deeper processor idle level: level 2, level 3 or level 4. When a trigger read is decoded, the block raises a stop-clock request and reports the idle level it is holding. It keeps that level until a break event brings it back to running. The trigger bytes have no storage. A read returns zero and a write does nothing, so the read itself is the command.

The bus carries dword addresses with byte enables, so a single access can touch more than one trigger byte. A fixed priority settles those collisions. A configuration input promotes a level 3 request to level 4. The throttle request is passed to the throttle output, except while the block holds level 2, when it is masked.

Top module: `sleep_trigger_ctrl`

## Requirements
- R1: A read counts as decoded when all of these hold: `bus_rd`=1, `bus_wr`=0, `bus_addr[15:7]` equals `pm_base`, and `bus_addr[6:2]`=5 (byte offsets 14h..17h). Under those conditions, byte lane 0 (offset 14h) requests level 2, lane 1 (15h) requests level 3 and lane 2 (16h) requests level 4. From running, `idle_state` takes the requested level at the next clock edge. The encoding is 00 running, 01 level 2, 10 level 3, 11 level 4.
- R2: On the clock edge after a decoded trigger read, `rd_hit` is 1 and `rd_data` is 0. After any other cycle, `rd_hit` is 0.
- R3: A write (`bus_wr`=1) to the trigger bytes changes neither `idle_state` nor `stop_clk`.
- R4: `stop_clk` becomes 1 on the same edge that `idle_state` leaves 00. It then stays 1 for as long as `brk_evt` is low.
- R5: When `c3_to_c4`=1, a level 3 request enters level 4 (11) instead.
- R6: When one access enables several trigger lanes, the lowest level wins. Level 2 beats level 3, and level 3 (or its promotion) beats level 4.
- R7: A trigger read that arrives while `idle_state` is not 00 is ignored, and the held level does not change.
- R8: When `brk_evt`=1 at a clock edge, `idle_state` becomes 00 and `stop_clk` becomes 0. A trigger read in the same cycle as a break event is ignored.
- R9: `thr_active` follows `thr_en` OR `thr_force` with one cycle of latency. It is forced to 0 in any cycle in which `idle_state` is 01.
- R10: While `rst` is high, or after it is released, the outputs are `idle_state`=00, `stop_clk`=0, `rd_hit`=0, `thr_active`=0 and `rd_data`=0.
- R11: The following have no effect: a read of lane 3, a read in another dword, and a read whose upper address bits do not match `pm_base`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_base | input | 9 | Power-management window base, address bits 15:7 |
| bus_addr | input | 14 | Dword address of the access, byte address bits 15:2 |
| bus_be | input | 4 | Byte lane enables of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| c3_to_c4 | input | 1 | Promote level 3 requests to level 4 |
| brk_evt | input | 1 | Break event, returns the block to running |
| thr_en | input | 1 | Throttle enable |
| thr_force | input | 1 | Forced throttle request |
| rd_data | output | 32 | Read data, always zero |
| rd_hit | output | 1 | A trigger byte was read in the previous cycle |
| stop_clk | output | 1 | Stop-clock request to clock control |
| idle_state | output | 2 | Current idle level |
| thr_active | output | 1 | Throttle request after level 2 masking |

## Verification
Some properties are checked by assertions on every cycle. A held level stays stable until a break, and `stop_clk` stays asserted while a level is held. A break always returns the block to running. The throttle output is low in level 2. A level 2 collision and a promoted level 3 request land in the right state. The bench scenarios cover the rest: the exact address window and lane decoding, the zero read data, that writes and out-of-window reads are ignored, the throttle pass-through latency, and the reset values.

// File: rtl/sleep_trigger_pkg.sv
package sleep_trigger_pkg;
  typedef enum logic [1:0] {
    IDLE_RUN = 2'b00,
    IDLE_L2  = 2'b01,
    IDLE_L3  = 2'b10,
    IDLE_L4  = 2'b11
  } idle_lvl_t;
endpackage

// File: rtl/sleep_addr_decode.sv
module sleep_addr_decode #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 7,
  parameter int FIRST_OFS  = 'h14,
  parameter int NUM_LVL    = 3
) (
  input  logic                          rd,
  input  logic                          wr,
  input  logic [ADDR_W-1:$clog2(DATA_W/8)] addr,
  input  logic [ADDR_W-1:ALIGN_BITS]    base,
  input  logic [DATA_W/8-1:0]           be,
  output logic [NUM_LVL-1:0]            lvl_hit
);
  localparam int LANE_BITS = $clog2(DATA_W / 8);

  logic in_window;
  // a cycle carrying a write strobe is never a trigger read
  assign in_window = rd && !wr && (addr[ADDR_W-1:ALIGN_BITS] == base);

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lane
    localparam logic [ALIGN_BITS-1:0] OFS_V = ALIGN_BITS'(FIRST_OFS + g);
    assign lvl_hit[g] = in_window
                        && (addr[ALIGN_BITS-1:LANE_BITS] == OFS_V[ALIGN_BITS-1:LANE_BITS])
                        && be[OFS_V[LANE_BITS-1:0]];
  end
endmodule

// File: rtl/sleep_req_arb.sv
module sleep_req_arb
  import sleep_trigger_pkg::*;
#(
  parameter int NUM_LVL     = 3,
  parameter int PROMOTE_IDX = 1
) (
  input  logic [NUM_LVL-1:0] lvl_hit,
  input  logic               promote,
  output logic               req_vld,
  output idle_lvl_t          req_lvl
);
  always_comb begin
    req_vld = 1'b0;
    req_lvl = IDLE_RUN;
    // walk from the deepest level down so the shallowest hit is kept
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (lvl_hit[i]) begin
        req_vld = 1'b1;
        if (promote && (i == PROMOTE_IDX))
          req_lvl = idle_lvl_t'(2'(i + 2));
        else
          req_lvl = idle_lvl_t'(2'(i + 1));
      end
    end
  end
endmodule

// File: rtl/sleep_state_fsm.sv
module sleep_state_fsm
  import sleep_trigger_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      req_vld,
  input  idle_lvl_t req_lvl,
  input  logic      brk,
  input  logic      thr_req,
  output idle_lvl_t state_o,
  output logic      stop_o,
  output logic      thr_o
);
  idle_lvl_t state_q, state_d;
  logic      stop_q, thr_q;

  always_comb begin
    state_d = state_q;
    if (brk)
      state_d = IDLE_RUN;
    else if ((state_q == IDLE_RUN) && req_vld)
      state_d = req_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= IDLE_RUN;
      stop_q  <= 1'b0;
      thr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stop_q  <= (state_d != IDLE_RUN);
      thr_q   <= thr_req && (state_d != IDLE_L2);
    end
  end

  assign state_o = state_q;
  assign stop_o  = stop_q;
  assign thr_o   = thr_q;

  // R7: a held level only leaves on a break
  p_hold_level_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q != IDLE_RUN && !brk) |=> $stable(state_q));

  // R4: stop-clock stays asserted until a break
  p_stop_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (stop_q && !brk) |=> stop_q);

  // R8: a break always returns to running with the clock released
  p_break_run_r8: assert property (@(posedge clk) disable iff (rst)
    brk |=> (state_q == IDLE_RUN && !stop_q));

  // R9: throttling masked while in level 2
  p_no_thr_l2_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == IDLE_L2) |-> !thr_q);
endmodule

// File: rtl/sleep_trigger_ctrl.sv
module sleep_trigger_ctrl
  import sleep_trigger_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 7,
  parameter int FIRST_OFS  = 'h14,
  parameter int NUM_LVL    = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-ALIGN_BITS-1:0] pm_base,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] bus_addr,
  input  logic [DATA_W/8-1:0]          bus_be,
  input  logic                         bus_rd,
  input  logic                         bus_wr,
  input  logic                         c3_to_c4,
  input  logic                         brk_evt,
  input  logic                         thr_en,
  input  logic                         thr_force,
  output logic [DATA_W-1:0]            rd_data,
  output logic                         rd_hit,
  output logic                         stop_clk,
  output logic [1:0]                   idle_state,
  output logic                         thr_active
);
  logic [NUM_LVL-1:0] lvl_hit;
  logic               req_vld;
  idle_lvl_t          req_lvl;
  idle_lvl_t          state;
  logic               hit_q;
  logic [DATA_W-1:0]  rdata_q;

  sleep_addr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS),
    .FIRST_OFS(FIRST_OFS), .NUM_LVL(NUM_LVL)
  ) u_dec (
    .rd(bus_rd), .wr(bus_wr), .addr(bus_addr), .base(pm_base),
    .be(bus_be), .lvl_hit(lvl_hit)
  );

  sleep_req_arb #(.NUM_LVL(NUM_LVL), .PROMOTE_IDX(1)) u_arb (
    .lvl_hit(lvl_hit), .promote(c3_to_c4),
    .req_vld(req_vld), .req_lvl(req_lvl)
  );

  sleep_state_fsm u_fsm (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_lvl(req_lvl),
    .brk(brk_evt), .thr_req(thr_en | thr_force),
    .state_o(state), .stop_o(stop_clk), .thr_o(thr_active)
  );

  // trigger bytes hold nothing: reads return zero
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      hit_q   <= |lvl_hit;
      rdata_q <= '0;
    end
  end

  assign rd_hit     = hit_q;
  assign rd_data    = rdata_q;
  assign idle_state = state;

  // R6: level 2 lane wins any collision taken from running
  p_l2_wins_r6: assert property (@(posedge clk) disable iff (rst)
    (state == IDLE_RUN && !brk_evt && lvl_hit[0]) |=> (idle_state == 2'b01));

  // R5: promoted level 3 request lands in level 4
  p_promote_r5: assert property (@(posedge clk) disable iff (rst)
    (state == IDLE_RUN && !brk_evt && lvl_hit[1] && !lvl_hit[0] && c3_to_c4)
    |=> (idle_state == 2'b11));
endmodule

// File: tb/sleep_trigger_ctrl_test.sv
module sleep_trigger_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  pm_base = '0;
  logic [13:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, c3_to_c4 = 1'b0;
  logic        brk_evt = 1'b0, thr_en = 1'b0, thr_force = 1'b0;
  logic [31:0] rd_data;
  logic        rd_hit, stop_clk, thr_active;
  logic [1:0]  idle_state;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sleep_trigger_ctrl uut (
    .clk(clk), .rst(rst), .pm_base(pm_base), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_rd(bus_rd), .bus_wr(bus_wr), .c3_to_c4(c3_to_c4),
    .brk_evt(brk_evt), .thr_en(thr_en), .thr_force(thr_force),
    .rd_data(rd_data), .rd_hit(rd_hit), .stop_clk(stop_clk),
    .idle_state(idle_state), .thr_active(thr_active)
  );

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] addr;
    logic [3:0]  be;
    logic        rd;
    logic        wr;
    logic        prom;
    logic [1:0]  exp_st;
    logic        exp_hit;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VT [NV] = '{
    '{16'h0400, 16'h0414, 4'b0001, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1}, // R1 lane0
    '{16'h0400, 16'h0414, 4'b0010, 1'b1, 1'b0, 1'b0, 2'b10, 1'b1}, // R1 lane1
    '{16'h0400, 16'h0414, 4'b0100, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1}, // R1 lane2
    '{16'h0400, 16'h0414, 4'b0010, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1}, // R5
    '{16'h0400, 16'h0414, 4'b0011, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1}, // R6 L2 over L3
    '{16'h0400, 16'h0414, 4'b0110, 1'b1, 1'b0, 1'b0, 2'b10, 1'b1}, // R6 L3 over L4
    '{16'h0400, 16'h0414, 4'b0110, 1'b1, 1'b0, 1'b1, 2'b11, 1'b1}, // R6 promoted
    '{16'h0400, 16'h0414, 4'b1000, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}, // R11 lane3
    '{16'h0400, 16'h0814, 4'b0001, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}, // R11 base
    '{16'h0400, 16'h0410, 4'b0001, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}, // R11 dword
    '{16'h0400, 16'h0414, 4'b0111, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R3 write
    '{16'h0480, 16'h0494, 4'b0001, 1'b1, 1'b0, 1'b0, 2'b01, 1'b1}, // R1 bit7 base
    '{16'h0400, 16'h0494, 4'b0001, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0}  // R11 bit7
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_trig(input logic [15:0] a, input logic [3:0] be);
    bus_addr = a[15:2];
    bus_be   = be;
    bus_rd   = 1'b1;
    tick();
    bus_rd   = 1'b0;
    bus_be   = '0;
  endtask

  task automatic do_break();
    brk_evt = 1'b1;
    tick();
    brk_evt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    pm_base = 9'h008;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk(idle_state == 2'b00, "R10 state in reset", idle_state, 0);
    chk(stop_clk == 1'b0 && rd_hit == 1'b0 && thr_active == 1'b0 && rd_data == 0,
        "R10 outputs in reset", {stop_clk, rd_hit, thr_active}, 0);
    rst = 1'b0;
    tick();
    chk(idle_state == 2'b00 && !stop_clk, "R10 after release", idle_state, 0);

    for (int i = 0; i < NV; i++) begin
      pm_base  = VT[i].base[15:7];
      c3_to_c4 = VT[i].prom;
      bus_addr = VT[i].addr[15:2];
      bus_be   = VT[i].be;
      bus_rd   = VT[i].rd;
      bus_wr   = VT[i].wr;
      tick();
      bus_rd = 1'b0;
      bus_wr = 1'b0;
      bus_be = '0;
      chk(idle_state == VT[i].exp_st, $sformatf("R1 vector %0d state", i),
          idle_state, VT[i].exp_st);
      chk(rd_hit == VT[i].exp_hit, $sformatf("R2 vector %0d hit", i), rd_hit, VT[i].exp_hit);
      chk(rd_data == 32'h0, $sformatf("R2 vector %0d data", i), rd_data, 0);
      chk(stop_clk == (VT[i].exp_st != 2'b00), $sformatf("R4 vector %0d stop", i),
          stop_clk, (VT[i].exp_st != 2'b00));
      do_break();
      chk(idle_state == 2'b00 && !stop_clk, $sformatf("R8 vector %0d break", i),
          idle_state, 0);
    end
    pm_base  = 9'h008;
    c3_to_c4 = 1'b0;

    // R4 hold and R7 ignore while busy
    rd_trig(16'h0415, 4'b0010);
    repeat (5) tick();
    chk(idle_state == 2'b10 && stop_clk, "R4 level 3 held", idle_state, 2);
    rd_trig(16'h0414, 4'b0001);
    chk(idle_state == 2'b10, "R7 level 2 read ignored in level 3", idle_state, 2);
    chk(rd_hit == 1'b1, "R2 hit while busy", rd_hit, 1);
    tick();
    chk(rd_hit == 1'b0, "R2 hit clears", rd_hit, 0);
    do_break();
    chk(idle_state == 2'b00, "R8 back to run", idle_state, 0);

    // R8 trigger together with break is ignored
    brk_evt = 1'b1;
    rd_trig(16'h0414, 4'b0001);
    brk_evt = 1'b0;
    chk(idle_state == 2'b00 && !stop_clk, "R8 trigger with break ignored", idle_state, 0);

    // R9 throttle pass-through and level 2 masking
    thr_en = 1'b1;
    tick();
    chk(thr_active == 1'b1, "R9 throttle in run", thr_active, 1);
    rd_trig(16'h0414, 4'b0001);
    chk(thr_active == 1'b0, "R9 throttle masked in level 2", thr_active, 0);
    do_break();
    chk(thr_active == 1'b1, "R9 throttle after break", thr_active, 1);
    thr_en = 1'b0;
    thr_force = 1'b1;
    rd_trig(16'h0416, 4'b0100);
    chk(thr_active == 1'b1 && idle_state == 2'b11, "R9 forced throttle in level 4",
        thr_active, 1);
    thr_force = 1'b0;
    tick();
    chk(thr_active == 1'b0, "R9 throttle drops", thr_active, 0);

    // R3 write while held does nothing
    bus_addr = 14'h0105;
    bus_be   = 4'b0111;
    bus_wr   = 1'b1;
    tick();
    bus_wr = 1'b0;
    chk(idle_state == 2'b11 && stop_clk, "R3 write while held", idle_state, 3);

    // R10 reset from a held state
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk(idle_state == 2'b00 && !stop_clk && !thr_active, "R10 reset from level 4",
        idle_state, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule